// File: doc/BRIEF.md
# Fixed-Point Systolic MAC Array

This block is a square grid of multiply-accumulate cells that works in signed Q8.8 fixed point: every operand and every partial sum is a 16-bit two's complement number with 8 fractional bits. Activations enter on the left edge, one value per row, and step one cell to the right on each advancing clock edge. Weights enter on the top edge, one value per column, and step one cell down beside the partial sums. Each partial sum starts at zero above the top row, picks up one clipped product in every row, and leaves through a register at the bottom of its column. The side of the grid is a parameter with a default of 2.

The caller skews its operands before they reach the ports. A logical vector k places the activation for row i on the left edge i cycles after cycle k, and the weight for column j on the top edge j cycles after cycle k. The valid strobe for vector k is given unskewed at cycle k. Inside the block the strobe is delayed per column so that it leaves the bottom together with its result.

The input and output streams follow valid/ready rules. A single `out_ready` input stalls the whole grid. `in_ready` is a combinational copy of `out_ready`, so a vector is accepted only on an edge where the grid advances. While `out_ready` is low, the outputs hold their values and the inputs are ignored. Each cell also has its own enable bit. A cleared bit turns that cell off for computation but does not stop the valid flow.

Top module: `sa_array`

## Requirements
- R1: A cell's product is floor(a*w / 256), taken from the full-width signed product, and then clipped to the range -32768..32767.
- R2: The result for column j is a running sum that starts at zero and adds the clipped products of rows 0, 1, ..., SIDE-1 in that order. Each addition is clipped to -32768..32767 before the next row adds its product.
- R3: Activation row i sits at `act_in[i*16 +: 16]` and weight column j sits at `wt_in[j*16 +: 16]`. Logical vector k is presented as follows: row i at advancing cycle k+i, column j at cycle k+j, and `in_valid` at cycle k. Its column j result is shown with `out_valid[j]` high exactly SIDE+j advancing edges after the edge that accepted `in_valid`.
- R4: One vector is accepted on every advancing edge. A run of back-to-back vectors yields back-to-back results in every column, and every accepted vector yields exactly one result per column.
- R5: `in_ready` equals `out_ready`. On an edge where `out_ready` is low, no state changes: `out_data` and `out_valid` stay as they were, and the input values are ignored.
- R6: Enable bit `pe_en[r*SIDE+c]` belongs to the cell in row r and column c. While that bit is low, on each advancing edge:
  - the cell's partial-sum register loads zero;
  - its activation and weight registers keep their values;
  - the valid flag passes through unchanged.
- R7: `ovf_flag` goes high after any advancing edge on which an enabled cell clipped a product or a sum. It stays high until reset.
- R8: `rst` is asynchronous and active high. It clears every register, so `out_valid`, `out_data` and `ovf_flag` read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Marks the cycle of a logical vector (unskewed) |
| in_ready | output | 1 | Vector accepted when high together with in_valid |
| act_in | input | SIDE*16 | Left-edge activations, row i at bits i*16 +: 16 |
| wt_in | input | SIDE*16 | Top-edge weights, column j at bits j*16 +: 16 |
| pe_en | input | SIDE*SIDE | Per-cell enable, cell (r,c) at bit r*SIDE+c |
| out_valid | output | SIDE | Result present on column j |
| out_ready | input | 1 | Consumer accepts; low stalls the whole grid |
| out_data | output | SIDE*16 | Bottom-edge results, column j at bits j*16 +: 16 |
| ovf_flag | output | 1 | Sticky clipping indicator |

## Verification
Two events can fall in the same cycle: a stall from `out_ready` and a valid result sitting at the bottom edge. A random stall pattern is applied while a long run of vectors is streamed, so many stalls land on cycles where some column is presenting a result. On every such cycle, the next sample must show the same data and valid values as before, and the scoreboard must still receive each expected result exactly once and in order. Clipping in the multiplier and clipping in the adder can also occur in the same cell and cycle; dedicated vectors force both, and the expected values are computed with the row-by-row clipping order.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int unsigned SA_DW_DEFAULT = 16;
  localparam int unsigned SA_FW_DEFAULT = 8;

  // Clip a wide signed value to a w-bit signed range; hit reports clipping.
  function automatic logic signed [63:0] clip_to(input logic signed [63:0] x,
                                                 input int unsigned w,
                                                 output logic hit);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    hit = 1'b1;
    if (x > hi) begin
      clip_to = hi;
    end else if (x < lo) begin
      clip_to = lo;
    end else begin
      clip_to = x;
      hit = 1'b0;
    end
  endfunction

endpackage

// File: rtl/sa_fwd.sv
module sa_fwd #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] d,
  output logic signed [DW-1:0] q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

  // R5/R6: operand registers hold whenever the grid stalls or the cell is off
  assert_fwd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

endmodule

// File: rtl/sa_vdelay.sv
module sa_vdelay #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sr <= '0;
    end else if (adv) begin
      sr[0] <= d;
      for (int k = 1; k < int'(DEPTH); k++) begin
        sr[k] <= sr[k-1];
      end
    end
  end

  assign q = sr[DEPTH-1];

  assert_vdelay_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(sr));

endmodule

// File: rtl/sa_pe.sv
module sa_pe
  import sa_pkg::*;
#(
  parameter int unsigned DW = SA_DW_DEFAULT,
  parameter int unsigned FW = SA_FW_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 en,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [DW-1:0] w_in,
  input  logic signed [DW-1:0] p_in,
  input  logic                 v_in,
  output logic signed [DW-1:0] p_out,
  output logic                 v_out,
  output logic                 sat_hit
);

  logic signed [63:0] prod_w;
  logic signed [63:0] prod_c;
  logic signed [63:0] sum_w;
  logic signed [DW-1:0] sum_c;
  logic hit_m;
  logic hit_a;
  logic signed [DW-1:0] p_q;
  logic v_q;

  // Full-width product, arithmetic shift to Q8.8 (floor), clip, then clipped add
  always_comb begin
    prod_w = 64'(a_in) * 64'(w_in);
    prod_c = clip_to(prod_w >>> FW, DW, hit_m);
    sum_w  = 64'(p_in) + prod_c;
    sum_c  = DW'(clip_to(sum_w, DW, hit_a));
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      p_q <= '0;
      v_q <= 1'b0;
    end else if (adv) begin
      v_q <= v_in;
      p_q <= en ? sum_c : '0;
    end
  end

  assign p_out   = p_q;
  assign v_out   = v_q;
  assign sat_hit = adv & en & (hit_m | hit_a);

  assert_pe_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(p_q) && $stable(v_q));

  assert_pe_off_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && !en) |=> (p_q == '0));

  assert_pe_valid_flow_R6: assert property (@(posedge clk) disable iff (rst)
    adv |=> (v_q == $past(v_in)));

endmodule

// File: rtl/sa_array.sv
module sa_array
  import sa_pkg::*;
#(
  parameter int unsigned SIDE = 2,
  parameter int unsigned DW   = SA_DW_DEFAULT,
  parameter int unsigned FW   = SA_FW_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SIDE*DW-1:0]   act_in,
  input  logic [SIDE*DW-1:0]   wt_in,
  input  logic [SIDE*SIDE-1:0] pe_en,
  output logic [SIDE-1:0]      out_valid,
  input  logic                 out_ready,
  output logic [SIDE*DW-1:0]   out_data,
  output logic                 ovf_flag
);

  localparam int unsigned NPE = SIDE * SIDE;

  logic signed [DW-1:0] a_op [SIDE][SIDE];
  logic signed [DW-1:0] w_op [SIDE][SIDE];
  logic signed [DW-1:0] p_bus [SIDE+1][SIDE];
  logic                 v_bus [SIDE+1][SIDE];
  logic [NPE-1:0]       pe_hit;
  logic                 adv;

  assign adv      = out_ready;
  assign in_ready = out_ready;

  genvar r, c;
  generate
    for (r = 0; r < SIDE; r++) begin : g_row_edge
      assign a_op[r][0] = act_in[r*DW +: DW];
    end

    for (c = 0; c < SIDE; c++) begin : g_col_edge
      assign w_op[0][c]  = wt_in[c*DW +: DW];
      assign p_bus[0][c] = '0;
      if (c == 0) begin : g_v0
        assign v_bus[0][c] = in_valid;
      end else begin : g_vd
        sa_vdelay #(.DEPTH(c)) u_vdelay (
          .clk(clk), .rst(rst), .adv(adv), .d(in_valid), .q(v_bus[0][c])
        );
      end
      assign out_data[c*DW +: DW] = p_bus[SIDE][c];
      assign out_valid[c]         = v_bus[SIDE][c];
    end

    for (r = 0; r < SIDE; r++) begin : g_r
      for (c = 0; c < SIDE; c++) begin : g_c
        sa_pe #(.DW(DW), .FW(FW)) u_pe (
          .clk(clk), .rst(rst), .adv(adv), .en(pe_en[r*SIDE+c]),
          .a_in(a_op[r][c]), .w_in(w_op[r][c]), .p_in(p_bus[r][c]),
          .v_in(v_bus[r][c]), .p_out(p_bus[r+1][c]), .v_out(v_bus[r+1][c]),
          .sat_hit(pe_hit[r*SIDE+c])
        );
        if (c < SIDE - 1) begin : g_afwd
          sa_fwd #(.DW(DW)) u_afwd (
            .clk(clk), .rst(rst), .en(adv & pe_en[r*SIDE+c]),
            .d(a_op[r][c]), .q(a_op[r][c+1])
          );
        end
        if (r < SIDE - 1) begin : g_wfwd
          sa_fwd #(.DW(DW)) u_wfwd (
            .clk(clk), .rst(rst), .en(adv & pe_en[r*SIDE+c]),
            .d(w_op[r][c]), .q(w_op[r+1][c])
          );
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ovf_flag <= 1'b0;
    end else if (|pe_hit) begin
      ovf_flag <= 1'b1;
    end
  end

  assert_out_stall_R5: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> $stable(out_data) && $stable(out_valid));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  assert_ovf_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (|pe_hit) |=> ovf_flag);

endmodule

// File: tb/sa_array_test.sv
module sa_array_test;

  localparam int CLK_P = 10;
  localparam int SAMP  = CLK_P * 3 / 4;
  localparam int SIDE  = 3;
  localparam int DW    = 16;
  localparam int FW    = 8;
  localparam int MAXV  = 64;
  localparam longint HI = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint LO = -(64'sd1 <<< (DW - 1));

  logic                 clk;
  logic                 rst;
  logic                 in_valid;
  logic                 in_ready;
  logic [SIDE*DW-1:0]   act_in;
  logic [SIDE*DW-1:0]   wt_in;
  logic [SIDE*SIDE-1:0] pe_en;
  logic [SIDE-1:0]      out_valid;
  logic                 out_ready;
  logic [SIDE*DW-1:0]   out_data;
  logic                 ovf_flag;

  sa_array #(.SIDE(SIDE), .DW(DW), .FW(FW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .act_in(act_in), .wt_in(wt_in), .pe_en(pe_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .ovf_flag(ovf_flag)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int t0 = 0;
  int unsigned lfsr = 32'h1F2E3D4C;
  bit done = 0;

  logic signed [DW-1:0] va [MAXV][SIDE];
  logic signed [DW-1:0] vw [MAXV][SIDE];
  logic signed [DW-1:0] exp_q [SIDE][$];
  int first_seen [SIDE];
  int last_seen [SIDE];
  logic signed [DW-1:0] prev_data [SIDE];
  bit prev_valid [SIDE];
  bit prev_ready = 0;

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  function automatic logic signed [DW-1:0] small_val();
    int x;
    x = int'(step_lfsr() % 1024) - 512;
    return DW'(x);
  endfunction

  function automatic longint bclip(input longint x, inout bit flag);
    if (x > HI) begin flag = 1; return HI; end
    if (x < LO) begin flag = 1; return LO; end
    return x;
  endfunction

  // Expected column result: row-ordered, clipped after every step (R1, R2)
  function automatic longint ref_col(input int v, input int j, inout bit flag);
    longint acc;
    longint p;
    acc = 0;
    for (int i = 0; i < SIDE; i++) begin
      p = (longint'(va[v][i]) * longint'(vw[v][j])) >>> FW;
      p = bclip(p, flag);
      acc = bclip(acc + p, flag);
    end
    return acc;
  endfunction

  // Driver: skews vectors onto the edges and pushes expected results
  task automatic run_stream(input int first, input int count, input bit stall, input bit enabled);
    int t;
    int total;
    bit flag;
    t = 0;
    total = count + 2*SIDE + 2;
    while (t < total) begin
      @(negedge clk);
      pe_en = enabled ? '1 : '0;
      out_ready = (stall && (step_lfsr() % 3 == 0)) ? 1'b0 : 1'b1;
      in_valid = (t < count);
      for (int i = 0; i < SIDE; i++) begin
        int k = t - i;
        act_in[i*DW +: DW] = (k >= 0 && k < count) ? va[first+k][i] : '0;
      end
      for (int j = 0; j < SIDE; j++) begin
        int k = t - j;
        wt_in[j*DW +: DW] = (k >= 0 && k < count) ? vw[first+k][j] : '0;
      end
      if (t == 0) t0 = cyc;
      if (out_ready && t < count) begin
        for (int j = 0; j < SIDE; j++) begin
          flag = 0;
          exp_q[j].push_back(enabled ? DW'(ref_col(first + t, j, flag)) : '0);
        end
      end
      if (out_ready) t++;
    end
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b0;
  endtask

  // Monitor: samples after the edge and after the negedge drive
  initial begin
    for (int j = 0; j < SIDE; j++) begin
      first_seen[j] = -1;
      last_seen[j] = -1;
      prev_valid[j] = 0;
      prev_data[j] = '0;
    end
    forever begin
      @(posedge clk);
      #(SAMP);
      if (!rst) begin
        for (int j = 0; j < SIDE; j++) begin
          logic signed [DW-1:0] got;
          got = $signed(out_data[j*DW +: DW]);
          if (prev_valid[j] && !prev_ready) begin
            check(out_valid[j] && got == prev_data[j], "R5 stalled output held", got, prev_data[j]);
          end
          if (out_valid[j]) begin
            if (first_seen[j] < 0) first_seen[j] = cyc;
            last_seen[j] = cyc;
          end
          if (out_valid[j] && out_ready) begin
            if (exp_q[j].size() == 0) begin
              check(0, "R4 unexpected result", got, 0);
            end else begin
              logic signed [DW-1:0] e;
              e = exp_q[j].pop_front();
              check(got == e, "R2 column result", got, e);
            end
          end
          prev_valid[j] = out_valid[j];
          prev_data[j] = got;
        end
        prev_ready = out_ready;
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; act_in = '0; wt_in = '0; pe_en = '1; out_ready = 1;
    repeat (2) @(negedge clk);
    // R8: reset state
    check(out_valid == '0, "R8 reset valid", out_valid, 0);
    check(out_data == '0, "R8 reset data", out_data, 0);
    check(ovf_flag == 0, "R8 reset overflow", ovf_flag, 0);
    out_ready = 0; #1;
    check(in_ready == 0, "R5 ready low follows", in_ready, 0);
    out_ready = 1; #1;
    check(in_ready == 1, "R5 ready high follows", in_ready, 1);
    @(negedge clk);
    rst = 0;

    // Stream A: floor rounding vector plus small values, no stall (R1, R3, R4)
    for (int v = 0; v < 8; v++)
      for (int i = 0; i < SIDE; i++) begin
        va[v][i] = small_val();
        vw[v][i] = small_val();
      end
    va[0][0] = 16'sd1;  va[0][1] = -16'sd1; va[0][2] = 16'sd256;
    vw[0][0] = -16'sd1; vw[0][1] = 16'sd3;  vw[0][2] = -16'sd700;
    run_stream(0, 8, 0, 1);
    for (int j = 0; j < SIDE; j++) begin
      check(first_seen[j] - t0 == SIDE + j, "R3 latency", first_seen[j] - t0, SIDE + j);
      check(last_seen[j] - first_seen[j] == 7, "R4 back-to-back", last_seen[j] - first_seen[j], 7);
    end
    check(ovf_flag == 0, "R7 no clipping yet", ovf_flag, 0);

    // Stream B: random stalls (R5)
    for (int v = 8; v < 20; v++)
      for (int i = 0; i < SIDE; i++) begin
        va[v][i] = small_val();
        vw[v][i] = small_val();
      end
    run_stream(8, 12, 1, 1);

    // Stream C: all cells off, garbage operands (R6); Stream D: recovery
    for (int v = 20; v < 27; v++)
      for (int i = 0; i < SIDE; i++) begin
        va[v][i] = v < 23 ? 16'sh7F00 : small_val();
        vw[v][i] = v < 23 ? 16'sh7F00 : small_val();
      end
    run_stream(20, 3, 0, 0);
    check(ovf_flag == 0, "R6 off cells raise nothing", ovf_flag, 0);
    run_stream(23, 4, 0, 1);

    // Stream E: clipping in multiplier and adder (R1, R2, R7)
    for (int v = 27; v < 32; v++)
      for (int i = 0; i < SIDE; i++) begin
        va[v][i] = '0;
        vw[v][i] = 16'sh0100;
      end
    va[27][0] = 16'sh7F00; vw[27][0] = 16'sh0200; vw[27][1] = 16'sh0200; vw[27][2] = 16'sh0200;
    va[28][0] = 16'sh6400; va[28][1] = 16'sh6400;
    va[29][0] = 16'sh8000; vw[29][0] = 16'sh8000; vw[29][1] = 16'sh8000; vw[29][2] = 16'sh8000;
    va[30][0] = 16'sh8000; va[30][1] = 16'sh8000; va[30][2] = 16'sh0100;
    va[31][0] = small_val(); va[31][1] = small_val();
    run_stream(27, 5, 0, 1);
    check(ovf_flag == 1, "R7 clipping seen", ovf_flag, 1);

    // Stream F: clean data, flag must stay (R7)
    for (int v = 32; v < 36; v++)
      for (int i = 0; i < SIDE; i++) begin
        va[v][i] = small_val();
        vw[v][i] = small_val();
      end
    run_stream(32, 4, 1, 1);
    check(ovf_flag == 1, "R7 flag sticky", ovf_flag, 1);
    for (int j = 0; j < SIDE; j++)
      check(exp_q[j].size() == 0, "R4 all results delivered", exp_q[j].size(), 0);

    rst = 1; #1;
    check(ovf_flag == 0, "R8 reset clears overflow", ovf_flag, 0);
    check(out_valid == '0, "R8 reset clears valid", out_valid, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule